// File: doc/BRIEF.md
# PWM Fault Auto-Shutdown Controller

This block sits between a PWM waveform generator and the output pins of a bridge driver. It watches three fault sources (two comparator trip lines and an active-low fault pin), and when any enabled source becomes active it forces all four PWM pins into programmed safe states. The override is purely combinational, so the pins reach their safe levels without waiting for a clock edge.

The pins come in two pairs: A with C, and B with D. Each pair has a 2-bit safe-state code that drives the pins low, drives them high, or releases them by dropping their output enables. A status flag records the shutdown. It is set by hardware from a synchronized copy of the fault, and software may also write it. When the flag clears, either automatically or by a software write, normal PWM drive returns only at the next period-start strobe from the PWM timer. A fault that reaches the pins therefore never ends part-way through a PWM period.

Top module: `pwm_fault_guard`

## Requirements
- R1: `src_sel` bit 0 enables comparator 1 (`trip_cmp1` high), bit 1 enables comparator 2 (`trip_cmp2` high), and bit 2 enables the fault pin (`fault_n` low). Any combination of these may be enabled, and the enabled sources are ORed.
- R2: With `src_sel` = 000, no fault input changes the pins or sets `shut_flag`.
- R3: While an enabled source is active, the pins show their safe states in the same cycle, with no clock edge in between.
- R4: Pins 0 (A) and 2 (C) use code `pair_safe[1:0]`, and pins 1 (B) and 3 (D) use code `pair_safe[3:2]`. Code 00 drives 0, code 01 drives 1, and code 1x drops the enable (`pin_oe`=0, `pin_out`=0). Enabled pins not in shutdown pass `pwm_in` with `pin_oe`=1.
- R5: `shut_flag` rises on the third rising edge after an enabled source becomes active: two synchronizer stages, then the flag register.
- R6: With `auto_restart`=1, `shut_flag` falls on the third rising edge after all enabled sources go inactive.
- R7: With `auto_restart`=0, `shut_flag` stays set after the fault is gone until a write of 0 (`flag_wr_en`=1, `flag_wr_data`=0). A write of 0 has no effect while the synchronized fault is active.
- R8: While `shut_flag` is set, and after it clears until a rising edge that samples `period_start`=1 with the flag already clear, every pin shows its safe state. Normal drive resumes in the cycle after that edge.
- R9: With no synchronized fault and `auto_restart`=0, a write of 1 sets `shut_flag` on the next edge and forces the safe states.
- R10: After reset, `shut_flag` is 0 and, with no fault active, the pins pass `pwm_in` with all enables at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_cmp1 | input | 1 | Comparator 1 trip, active high |
| trip_cmp2 | input | 1 | Comparator 2 trip, active high |
| fault_n | input | 1 | External fault pin, active low |
| src_sel | input | 3 | Source enables: bit0 cmp1, bit1 cmp2, bit2 fault pin |
| pair_safe | input | 4 | Safe codes: [1:0] pins A/C, [3:2] pins B/D |
| auto_restart | input | 1 | 1 = flag clears by itself once the fault is gone |
| period_start | input | 1 | One-cycle strobe at the start of each PWM period |
| flag_wr_en | input | 1 | Software write strobe for the status flag |
| flag_wr_data | input | 1 | Value written to the status flag |
| pwm_in | input | 4 | Normal PWM drive, bit order A, B, C, D |
| pin_out | output | 4 | Pin drive values |
| pin_oe | output | 4 | Pin output enables |
| shut_flag | output | 1 | Shutdown status flag |

## Verification
The bench sweeps every select value against each single source and checks the pins before any clock edge. A design that mapped a source to the wrong select bit, or that registered the override, would show PWM data where safe levels belong. It also runs every pair of safe codes against every PWM pattern, which catches swapped pairs or an enable left high on a tri-stated pin. The sequential cases measure the flag's set and clear latency in edges, try a blocked clearing write during an active fault, and hold the pins in their safe states until a period strobe is seen with the flag clear. A design that resumed as soon as the flag dropped, or that let the write clear the flag, fails these at a known cycle.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    localparam int NUM_SOURCES = 3;

    typedef struct packed {
        logic flag;
        logic hold;
    } guard_state_t;

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pfg_src_select.sv
module pfg_src_select #(
    parameter int NSRC = 3
) (
    input  logic [NSRC-1:0] trip_vec,
    input  logic [NSRC-1:0] enable,
    output logic            active
);

    logic [NSRC-1:0] masked;

    always_comb begin
        masked = trip_vec & enable;
        active = |masked;
    end

endmodule

// File: rtl/pfg_pin_drive.sv
module pfg_pin_drive #(
    parameter int NUM_PINS = 4,
    localparam int NUM_PAIRS = NUM_PINS / 2
) (
    input  logic                   shut,
    input  logic [2*NUM_PAIRS-1:0] pair_safe,
    input  logic [NUM_PINS-1:0]    pwm_in,
    output logic [NUM_PINS-1:0]    pin_out,
    output logic [NUM_PINS-1:0]    pin_oe
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam int PAIR = i % NUM_PAIRS;
        logic [1:0] code;
        always_comb begin
            code = pair_safe[2*PAIR +: 2];
            if (shut) begin
                pin_oe[i]  = ~code[1];
                pin_out[i] = ~code[1] & code[0];
            end else begin
                pin_oe[i]  = 1'b1;
                pin_out[i] = pwm_in[i];
            end
        end
    end

endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
    parameter int NUM_PINS    = 4,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_PAIRS  = NUM_PINS / 2,
    localparam int NSRC       = pfg_pkg::NUM_SOURCES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   trip_cmp1,
    input  logic                   trip_cmp2,
    input  logic                   fault_n,
    input  logic [NSRC-1:0]        src_sel,
    input  logic [2*NUM_PAIRS-1:0] pair_safe,
    input  logic                   auto_restart,
    input  logic                   period_start,
    input  logic                   flag_wr_en,
    input  logic                   flag_wr_data,
    input  logic [NUM_PINS-1:0]    pwm_in,
    output logic [NUM_PINS-1:0]    pin_out,
    output logic [NUM_PINS-1:0]    pin_oe,
    output logic                   shut_flag
);

    import pfg_pkg::*;

    logic [NSRC-1:0] trip_raw;
    logic [NSRC-1:0] trip_sync;
    logic            raw_active;
    logic            sync_active;
    logic            shut;

    guard_state_t st_d, st_q;

    assign trip_raw = {~fault_n, trip_cmp2, trip_cmp1};

    pfg_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trip_raw),
        .sync_out (trip_sync)
    );

    pfg_src_select #(.NSRC(NSRC)) u_sel_raw (
        .trip_vec (trip_raw),
        .enable   (src_sel),
        .active   (raw_active)
    );

    pfg_src_select #(.NSRC(NSRC)) u_sel_sync (
        .trip_vec (trip_sync),
        .enable   (src_sel),
        .active   (sync_active)
    );

    always_comb begin
        st_d = st_q;
        if (sync_active) begin
            st_d.flag = 1'b1;
        end else if (flag_wr_en) begin
            st_d.flag = flag_wr_data;
        end else if (auto_restart) begin
            st_d.flag = 1'b0;
        end
        if (st_d.flag) begin
            st_d.hold = 1'b1;
        end else if (period_start && !st_q.flag) begin
            st_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shut      = raw_active | st_q.hold;
    assign shut_flag = st_q.flag;

    pfg_pin_drive #(.NUM_PINS(NUM_PINS)) u_drive (
        .shut      (shut),
        .pair_safe (pair_safe),
        .pwm_in    (pwm_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // R3: an active enabled source shows driven safe levels at the pins
    p_override_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_sel & {~fault_n, trip_cmp2, trip_cmp1})) |->
            ((pair_safe[1] || pin_out[0] == pair_safe[0]) &&
             (pair_safe[3] || pin_out[1] == pair_safe[2])));

    // R4: tri-state codes drop the enables of their pair
    p_tristate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_sel & {~fault_n, trip_cmp2, trip_cmp1})) |->
            (pin_oe[0] == !pair_safe[1] && pin_oe[1] == !pair_safe[3]));

    // R5: synchronized fault sets the flag on the next edge
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_active |=> shut_flag);

    // R7: clearing write is ignored while the fault persists
    p_wr_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_active && flag_wr_en && !flag_wr_data) |=> shut_flag);

    // R8: pins stay safe while the flag is set
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shut_flag |-> (pin_oe[0] == !pair_safe[1] && pin_oe[1] == !pair_safe[3]));

    // R8: release of the hold only follows a period strobe with the flag clear
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.hold) |-> ($past(period_start) && !$past(shut_flag)));

endmodule

// File: tb/sim_pwm_fault_guard.sv
module sim_pwm_fault_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trip_cmp1 = 1'b0, trip_cmp2 = 1'b0, fault_n = 1'b1;
    logic [2:0] src_sel = '0;
    logic [3:0] pair_safe = '0;
    logic       auto_restart = 1'b0, period_start = 1'b0;
    logic       flag_wr_en = 1'b0, flag_wr_data = 1'b0;
    logic [3:0] pwm_in = '0;
    logic [3:0] pin_out, pin_oe;
    logic       shut_flag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwm_fault_guard u0 (
        .clk, .rst_n, .trip_cmp1, .trip_cmp2, .fault_n, .src_sel, .pair_safe,
        .auto_restart, .period_start, .flag_wr_en, .flag_wr_data, .pwm_in,
        .pin_out, .pin_oe, .shut_flag
    );

    function automatic logic [7:0] expect_pins(input logic [3:0] codes,
                                               input logic [3:0] pwm,
                                               input logic shut);
        logic [3:0] o, e;
        for (int i = 0; i < 4; i++) begin
            logic [1:0] c;
            c = (i == 0 || i == 2) ? codes[1:0] : codes[3:2];
            if (!shut) begin
                o[i] = pwm[i]; e[i] = 1'b1;
            end else if (c[1]) begin
                o[i] = 1'b0; e[i] = 1'b0;
            end else begin
                o[i] = c[0]; e[i] = 1'b1;
            end
        end
        return {e, o};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_pins(input string req, input logic shut);
        logic [7:0] exp;
        exp = expect_pins(pair_safe, pwm_in, shut);
        chk({pin_oe, pin_out} == exp, req, {pin_oe, pin_out}, exp);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_period();
        period_start = 1'b1;
        step(1);
        period_start = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        pwm_in = 4'b0110;
        step(3);
        rst_n = 1'b1;
        step(1);
        #1;
        chk(shut_flag == 1'b0, "R10 flag", shut_flag, 0);
        chk_pins("R10 pass", 1'b0);

        // R1 R2 R3: every select against every single source, no edge between
        auto_restart = 1'b1;
        for (int sel = 0; sel < 8; sel++) begin
            for (int src = 0; src < 3; src++) begin
                step(1);
                src_sel = sel[2:0];
                pair_safe = 4'((sel * 3 + src) % 16);
                pwm_in = 4'((sel + 5 * src) % 16);
                trip_cmp1 = (src == 0);
                trip_cmp2 = (src == 1);
                fault_n = !(src == 2);
                #1;
                chk_pins(sel == 0 ? "R2 disabled" : "R1 R3 select", sel[src]);
                trip_cmp1 = 1'b0; trip_cmp2 = 1'b0; fault_n = 1'b1;
            end
        end
        step(1);
        #1;
        chk(shut_flag == 1'b0, "R3 no edge seen", shut_flag, 0);

        // R4: every pair code against every PWM pattern
        src_sel = 3'b001;
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 16; p++) begin
                step(1);
                pair_safe = 4'(c);
                pwm_in = 4'(p);
                trip_cmp1 = 1'b1;
                #1;
                chk_pins("R4 codes", 1'b1);
                trip_cmp1 = 1'b0;
                #1;
                chk_pins("R4 pass", 1'b0);
            end
        end

        // R2: held faults with nothing enabled
        src_sel = 3'b000;
        trip_cmp1 = 1'b1; trip_cmp2 = 1'b1; fault_n = 1'b0;
        step(5);
        #1;
        chk(shut_flag == 1'b0, "R2 flag", shut_flag, 0);
        chk_pins("R2 pins", 1'b0);
        trip_cmp1 = 1'b0; trip_cmp2 = 1'b0; fault_n = 1'b1;
        step(4);

        // R5 R6 R8: automatic restart through the fault pin
        src_sel = 3'b100; auto_restart = 1'b1;
        pwm_in = 4'b1010; pair_safe = 4'b0100;
        fault_n = 1'b0;
        step(2);
        #1;
        chk(shut_flag == 1'b0, "R5 early", shut_flag, 0);
        step(1);
        #1;
        chk(shut_flag == 1'b1, "R5 set", shut_flag, 1);
        strobe_period();
        #1;
        chk_pins("R8 period while set", 1'b1);
        fault_n = 1'b1;
        #1;
        chk_pins("R8 held after fault", 1'b1);
        step(2);
        #1;
        chk(shut_flag == 1'b1, "R6 early", shut_flag, 1);
        step(1);
        #1;
        chk(shut_flag == 1'b0, "R6 clear", shut_flag, 0);
        chk_pins("R8 wait period", 1'b1);
        step(3);
        #1;
        chk_pins("R8 still waiting", 1'b1);
        strobe_period();
        #1;
        chk_pins("R8 resume", 1'b0);

        // R7: manual restart through comparator 1
        auto_restart = 1'b0; src_sel = 3'b001; pair_safe = 4'b1001;
        trip_cmp1 = 1'b1;
        step(4);
        #1;
        chk(shut_flag == 1'b1, "R7 set", shut_flag, 1);
        flag_wr_en = 1'b1; flag_wr_data = 1'b0;
        step(1);
        flag_wr_en = 1'b0;
        #1;
        chk(shut_flag == 1'b1, "R7 write blocked", shut_flag, 1);
        trip_cmp1 = 1'b0;
        step(5);
        #1;
        chk(shut_flag == 1'b1, "R7 sticky", shut_flag, 1);
        flag_wr_en = 1'b1; flag_wr_data = 1'b0;
        step(1);
        flag_wr_en = 1'b0;
        #1;
        chk(shut_flag == 1'b0, "R7 cleared", shut_flag, 0);
        chk_pins("R8 manual wait", 1'b1);
        strobe_period();
        #1;
        chk_pins("R8 manual resume", 1'b0);

        // R9: software forced shutdown
        src_sel = 3'b000; pair_safe = 4'b0001; pwm_in = 4'b1100;
        flag_wr_en = 1'b1; flag_wr_data = 1'b1;
        step(1);
        flag_wr_en = 1'b0;
        #1;
        chk(shut_flag == 1'b1, "R9 set", shut_flag, 1);
        chk_pins("R9 pins", 1'b1);
        flag_wr_en = 1'b1; flag_wr_data = 1'b0;
        step(1);
        flag_wr_en = 1'b0;
        strobe_period();
        #1;
        chk(shut_flag == 1'b0, "R9 clear", shut_flag, 0);
        chk_pins("R9 resume", 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule